// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Per-Field Repeat Masks

This block keeps four alarm bytes (second, minute, hour and day of month) and compares them with a BCD time of day. The time of day comes from an external counter. The comparison takes place only in the cycle where a one-second strobe is high. When the enabled fields all agree, the block emits an interrupt pulse that lasts one clock cycle. The block does not count time, roll over the calendar or implement any bus protocol. It only consumes the time presented on its inputs.

Bit 7 of each alarm byte means "ignore this field". Four mask patterns pick a repeat period: monthly, daily, hourly or once a minute. Every other pattern makes the alarm fire on every strobe. A byte-wide register port loads the alarm bytes. The port checks each written value as BCD and drops a value that is out of range, leaving the previous contents in place.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, the second, minute and hour alarm bytes read 0x00, the day byte reads 0x01, and irq_pulse is low.
- R2: Register index 0 is the second, 1 the minute, 2 the hour and 3 the day of month. In the cycle after reg_addr is presented, reg_rdata returns the whole byte last accepted at that index, including bit 7.
- R3: A write to index 0 or 1 is stored only if bits 6:0 form BCD with the low digit (bits 3:0) at most 9 and a value from 0 to 59. Otherwise the byte is unchanged.
- R4: A write to index 2 is stored only if bits 5:0 form BCD with the low digit at most 9 and a value from 0 to 23. Otherwise the byte is unchanged.
- R5: A write to index 3 is stored only if bits 5:0 form BCD with the low digit at most 9 and a non-zero value. Otherwise the byte is unchanged. This also applies when bit 7 is set.
- R6: With no mask bits set, a strobe fires when the day (bits 5:0), hour (bits 5:0), minute (bits 6:0) and second (bits 6:0) all equal the alarm bytes.
- R7: With only the day mask set, a strobe fires when the hour, minute and second match.
- R8: With the day and hour masks set, and the minute and second masks clear, a strobe fires when the minute and second match.
- R9: With the day, hour and minute masks set, and the second mask clear, a strobe fires when the second matches.
- R10: Every other mask pattern, including all four set, fires on every strobe.
- R11: irq_pulse goes high in the cycle after a qualifying strobe and stays high for that one cycle only. A cycle without the strobe never produces a pulse, whatever the time inputs hold.
- R12: While irq_en is low, a strobe that would qualify produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 second, 1 minute, 2 hour, 3 day) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| tod_sec | input | 8 | Current second, BCD |
| tod_min | input | 8 | Current minute, BCD |
| tod_hour | input | 8 | Current hour, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq_en | input | 1 | Alarm interrupt enable |
| irq_pulse | output | 1 | Single-cycle alarm interrupt |

## Verification
If an alarm byte is corrupted, for example by a rejected write that still lands, the byte shows up on reg_rdata at the next read of that index. That read takes one cycle. A wrong repeat-mode decode, or a wrong field width in the comparison, shows up as a missing or extra irq_pulse. It appears exactly one cycle after the strobe whose time values straddle the faulty bit. Random times are therefore drawn half from the alarm values themselves, so that near-matches are frequent. A pulse that lasts too long shows as irq_pulse high one cycle after a strobe-free edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD = 4;
  localparam int DW     = 8;
  localparam int AW     = $clog2(NFIELD);

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    RPT_MONTH  = 3'd0,
    RPT_DAY    = 3'd1,
    RPT_HOUR   = 3'd2,
    RPT_MINUTE = 3'd3,
    RPT_SECOND = 3'd4
  } repeat_e;

  // bits of each field that carry the BCD value
  function automatic logic [DW-1:0] value_bits(input int idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction

  // range check applied to a written alarm byte
  function automatic logic field_ok(input int idx, input logic [DW-1:0] v);
    logic [3:0] ones;
    logic [2:0] tens;
    int         val;
    ones = v[3:0];
    tens = v[6:4] & ((idx < 2) ? 3'b111 : 3'b011);
    val  = 32'(tens) * 10 + 32'(ones);
    if (ones > 4'd9) return 1'b0;
    case (idx)
      0, 1:    return val <= 59;
      2:       return val <= 23;
      default: return val != 0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter logic [DW-1:0] DATE_RST = 8'h01
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NFIELD-1:0][DW-1:0]  alarm_q
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam logic [DW-1:0] RST_V = (i == int'(FLD_DATE)) ? DATE_RST : '0;
    logic hit;
    assign hit = we && (addr == AW'(i)) && field_ok(i, wdata);
    always_ff @(posedge clk) begin
      if (rst)      alarm_q[i] <= RST_V;
      else if (hit) alarm_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= alarm_q[addr];
  end
endmodule

// File: rtl/alarm_mode_dec.sv
module alarm_mode_dec
  import rtc_alarm_pkg::*;
(
  input  logic [NFIELD-1:0] mask,   // bit i = mask of field i
  output repeat_e           mode,
  output logic [NFIELD-1:0] cmp_en
);
  always_comb begin
    case (mask)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RPT_MONTH:  cmp_en = 4'b1111;
      RPT_DAY:    cmp_en = 4'b0111;
      RPT_HOUR:   cmp_en = 4'b0011;
      RPT_MINUTE: cmp_en = 4'b0001;
      default:    cmp_en = 4'b0000;
    endcase
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NFIELD-1:0][DW-1:0] alarm_q,
  input  logic [NFIELD-1:0][DW-1:0] tod,
  input  logic [NFIELD-1:0]         cmp_en,
  input  logic                      tick,
  input  logic                      en,
  output logic                      pulse
);
  logic [NFIELD-1:0] eq;
  logic              hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_eq
    localparam logic [DW-1:0] VM = value_bits(i);
    assign eq[i] = ((alarm_q[i] & VM) == (tod[i] & VM)) || !cmp_en[i];
  end

  assign hit = &eq;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= tick && en && hit;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter logic [7:0] DATE_RST = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  input  logic [7:0] tod_sec,
  input  logic [7:0] tod_min,
  input  logic [7:0] tod_hour,
  input  logic [7:0] tod_date,
  input  logic       irq_en,
  output logic       irq_pulse
);
  logic [NFIELD-1:0][DW-1:0] alarm_q;
  logic [NFIELD-1:0][DW-1:0] tod;
  logic [NFIELD-1:0]         mask;
  logic [NFIELD-1:0]         cmp_en;
  repeat_e                   mode;

  assign tod = {tod_date, tod_hour, tod_min, tod_sec};

  for (genvar i = 0; i < NFIELD; i++) begin : g_mask
    assign mask[i] = alarm_q[i][DW-1];
  end

  alarm_regfile #(.DATE_RST(DATE_RST)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .alarm_q(alarm_q)
  );

  alarm_mode_dec u_mode (.mask(mask), .mode(mode), .cmp_en(cmp_en));

  alarm_cmp u_cmp (
    .clk(clk), .rst(rst), .alarm_q(alarm_q), .tod(tod), .cmp_en(cmp_en),
    .tick(sec_tick), .en(irq_en), .pulse(irq_pulse)
  );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            sec_tick,
  input logic            irq_en,
  input logic            irq_pulse,
  input logic [3:0][7:0] alarm_q
);
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(sec_tick));  // R11
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_en));  // R12
  AST_SEC_BAD_DIGIT: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0 && reg_wdata[3:0] > 4'd9) |=> $stable(alarm_q[0]));  // R3
  AST_HOUR_OVER: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2 && reg_wdata[5:4] == 2'd2 && reg_wdata[3:0] > 4'd3)
      |=> $stable(alarm_q[2]));  // R4
  AST_DATE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd3 && reg_wdata[5:0] == 6'd0) |=> $stable(alarm_q[3]));  // R5
  AST_ALL_MASKED_FIRES: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && irq_en && alarm_q[0][7] && alarm_q[1][7] && alarm_q[2][7] && alarm_q[3][7])
      |=> irq_pulse);  // R10
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sec_tick(sec_tick), .irq_en(irq_en),
  .irq_pulse(irq_pulse), .alarm_q(alarm_q)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sec_tick = 1'b0;
  logic [7:0] tod_sec = '0, tod_min = '0, tod_hour = '0, tod_date = 8'h01;
  logic irq_en = 1'b0;
  logic irq_pulse;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4];

  always #2.5 clk = ~clk;

  rtc_alarm_match uut (.*);

  task automatic chk(input logic ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic accept(input int idx, input logic [7:0] v);
    int t, o, val;
    o = int'(v[3:0]);
    t = (idx < 2) ? int'(v[6:4]) : int'(v[5:4]);
    val = t * 10 + o;
    if (o > 9) return 1'b0;
    if (idx < 2) return val <= 59;
    if (idx == 2) return val <= 23;
    return val != 0;
  endfunction

  function automatic logic exp_fire(input logic [7:0] s, input logic [7:0] m,
                                    input logic [7:0] h, input logic [7:0] d);
    logic [3:0] mk;
    logic es, em, eh, ed;
    mk = {model[3][7], model[2][7], model[1][7], model[0][7]};
    es = (s[6:0] == model[0][6:0]);
    em = (m[6:0] == model[1][6:0]);
    eh = (h[5:0] == model[2][5:0]);
    ed = (d[5:0] == model[3][5:0]);
    case (mk)
      4'b0000: return es && em && eh && ed;  // R6
      4'b1000: return es && em && eh;        // R7
      4'b1100: return es && em;              // R8
      4'b1110: return es;                    // R9
      default: return 1'b1;                  // R10
    endcase
  endfunction

  function automatic string wtag(input int a);
    return (a < 2) ? "R3" : (a == 2) ? "R4" : "R5";
  endfunction

  task automatic do_read(input int a, output logic [7:0] got);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'(a);
    @(posedge clk); #1;
    got = reg_rdata;
  endtask

  task automatic do_write(input int a, input logic [7:0] v);
    logic [7:0] got;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    if (accept(a, v)) model[a] = v;
    do_read(a, got);
    chk(got == model[a], {wtag(a), "/R2 write"}, int'(got), int'(model[a]));
  endtask

  task automatic do_tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] d, input logic en, input string tag);
    logic e;
    e = en && exp_fire(s, m, h, d);
    @(negedge clk);
    tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
    irq_en = en; sec_tick = 1'b1;
    @(posedge clk); #1;
    chk(irq_pulse == e, tag, int'(irq_pulse), int'(e));
    @(negedge clk);
    sec_tick = 1'b0;
    @(posedge clk); #1;
    chk(irq_pulse == 1'b0, "R11 pulse width", int'(irq_pulse), 0);
  endtask

  task automatic quiet_cycle(input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] d);
    @(negedge clk);
    tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
    irq_en = 1'b1; sec_tick = 1'b0;
    @(posedge clk); #1;
    chk(irq_pulse == 1'b0, "R11 no tick", int'(irq_pulse), 0);
  endtask

  function automatic logic [7:0] rnd_val(input int idx);
    if (idx < 2) return to_bcd(int'($urandom % 60));
    if (idx == 2) return to_bcd(int'($urandom % 24));
    return to_bcd(1 + int'($urandom % 31));
  endfunction

  function automatic logic [7:0] rnd_tod(input int idx);
    if ($urandom % 2 == 0) return model[idx] & ((idx < 2) ? 8'h7F : 8'h3F);
    return rnd_val(idx);
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [3:0] pats [5];
    void'($urandom(32'd4711));
    pats[0] = 4'b0000; pats[1] = 4'b1000; pats[2] = 4'b1100; pats[3] = 4'b1110;
    pats[4] = 4'b1111;
    model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    chk(irq_pulse == 1'b0, "R1 irq reset", int'(irq_pulse), 0);
    @(negedge clk) rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      do_read(a, got);
      chk(got == model[a], "R1 reset value", int'(got), int'(model[a]));
    end

    // directed write corners
    do_write(0, 8'h5A);  // bad low digit, R3
    do_write(0, 8'h60);  // 60 rejected, R3
    do_write(0, 8'hD9);  // mask + 59 accepted, R3
    do_write(1, 8'h3F);  // R3
    do_write(1, 8'h07);  // R3
    do_write(2, 8'h24);  // R4
    do_write(2, 8'h1A);  // R4
    do_write(2, 8'h23);  // R4
    do_write(3, 8'h00);  // R5
    do_write(3, 8'h80);  // masked zero still rejected, R5
    do_write(3, 8'h3C);  // R5
    do_write(3, 8'h31);  // R5
    do_write(0, 8'h45);

    // monthly match and near misses
    do_tick(8'h45, 8'h07, 8'h23, 8'h31, 1'b1, "R6 full match");
    do_tick(8'h45, 8'h07, 8'h23, 8'h30, 1'b1, "R6 date differs");
    quiet_cycle(8'h45, 8'h07, 8'h23, 8'h31);
    do_tick(8'h45, 8'h07, 8'h23, 8'h31, 1'b0, "R12 disabled");
    // every-second mode with mixed mask pattern
    do_write(1, 8'h87);
    do_tick(8'h00, 8'h00, 8'h00, 8'h02, 1'b1, "R10 odd mask");

    // random mode sweeps
    for (int it = 0; it < 60; it++) begin
      logic [3:0] p;
      p = pats[$urandom % 5];
      if (it % 5 == 4) p = 4'($urandom);
      for (int f = 0; f < 4; f++) do_write(f, {p[f], 7'(rnd_val(f))});
      if ($urandom % 4 == 0) do_write(int'($urandom % 4), 8'($urandom));
      for (int k = 0; k < 6; k++)
        do_tick(rnd_tod(0), rnd_tod(1), rnd_tod(2), rnd_tod(3), ($urandom % 8) != 0,
                "R6..R10 random mode R7 R8 R9 R12");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule